// File: doc/BRIEF.md
# Composite Sync Mixer and Output Router

This block sits after a video timing counter. It takes the separate line and field timing signals: horizontal and vertical sync, horizontal and vertical blank, two gating strobes, a cursor window and a field interrupt. It merges sync into a composite sync and blanking into a composite blank. While a programmed band of lines is current, it replaces the composite sync with equalization or serration pulses. These pulses can run once or twice per line.

A 12-bit status word controls the block. It selects what each of the four output pins carries, sets a polarity per pin, picks the pulse mode and can switch the pulse insertion off. Four further words give the pulse end positions and the first and last line of the pulse band. All four pins are registered, so each pin follows its inputs one clock later.

Top module: `sync_mix_router`

## Requirements
- R1: While `rst_n` is low at a rising edge, all four bits of `vid_pin` become 0. After that, every pin shows the function of the inputs sampled at the previous rising edge.
- R2: `status[2:0]` selects the pin functions as follows. Pin 0 carries vertical blank when bit 0 is 1, and composite blank otherwise. Pin 1 carries vertical sync when bit 1 is 1, and composite sync otherwise. Pin 2 carries horizontal blank when bit 0 is 1; otherwise it carries the cursor when bit 2 is 1 and the horizontal gate when bit 2 is 0. Pin 3 carries horizontal sync when bit 1 is 1; otherwise it carries the field interrupt when bit 2 is 1 and the vertical gate when bit 2 is 0.
- R3: Status bits 5, 6, 7 and 8 set the polarity of pins 0, 1, 2 and 3. A 1 drives the active function as 1 (active high). A 0 drives the inverse (active low).
- R4: Composite blank is horizontal blank OR vertical blank, formed before the polarity is applied.
- R5: Status bit 9 at 1 disables pulse insertion. Composite sync is then horizontal sync OR vertical sync on every line.
- R6: When status bit 9 is 0 and `v_line` lies between `win_first` and `win_last` inclusive, composite sync is the serration pulse if vertical sync is active, and the equalization pulse otherwise. Outside that band, composite sync is horizontal sync OR vertical sync.
- R7: The equalization pulse is active while the pulse phase is below `eq_end`. The serration pulse is active while the phase is below `serr_end`.
- R8: With `status[4:3]` = 11 (single rate), the phase equals `h_pos`. With 00 (interlaced) or 01 (progressive), pulses run at double rate. In double rate, with half = `h_total`/2 rounded down, the phase is `h_pos` - half when `h_pos` >= half, and `h_pos` otherwise. The pulses do not depend on the field.
- R9: The illegal mode value 10 behaves exactly like 01.
- R10: Inserted pulses appear only on composite sync. Pins that carry vertical sync, the blanks, the gates, the cursor or the interrupt are unaffected by the pulse band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status | input | 12 | Pin select [2:0], pulse mode [4:3], polarity [8:5], pulse disable [9] |
| h_pos | input | 12 | Clock position within the line |
| h_total | input | 12 | Clocks per line |
| v_line | input | 12 | Current line number |
| eq_end | input | 12 | Equalization pulse end phase |
| serr_end | input | 12 | Serration pulse end phase |
| win_first | input | 12 | First line of the pulse band |
| win_last | input | 12 | Last line of the pulse band |
| hsync_i | input | 1 | Horizontal sync, active high |
| hblank_i | input | 1 | Horizontal blank, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| vblank_i | input | 1 | Vertical blank, active high |
| hgate_i | input | 1 | Horizontal gate |
| vgate_i | input | 1 | Vertical gate |
| cursor_i | input | 1 | Cursor window |
| vint_i | input | 1 | Field interrupt |
| vid_pin | output | 4 | Routed, polarity-adjusted pins 0..3 |

## Verification
Pulse insertion and plain routing can act on the same cycle. A line inside the pulse band can carry vertical sync while pin 1 is switched between composite and vertical sync, and the bench drives exactly these cycles. It then judges that only the composite choice shows the serration pulse. The pulse phase can also fall exactly on the half-line fold point and on the pulse end values within a single band line. Directed cases place `h_pos` at half-1, half, `eq_end`-1 and `eq_end`. Random cycles mix every mode, select and polarity, and each result is compared with a bench model of the requirements.

// File: rtl/sync_mix_pkg.sv
// Package: shared widths, mode codes and the bundle of timing inputs.
package sync_mix_pkg;
    localparam int CW = 12;
    localparam logic [1:0] MODE_ILACE_DBL = 2'b00;
    localparam logic [1:0] MODE_PROG_DBL  = 2'b01;
    localparam logic [1:0] MODE_BAD       = 2'b10;
    localparam logic [1:0] MODE_PROG_SGL  = 2'b11;

    typedef struct packed {
        logic hsync;
        logic hblank;
        logic vsync;
        logic vblank;
        logic hgate;
        logic vgate;
        logic cursor;
        logic vint;
    } tsrc_t;
endpackage

// File: rtl/eqser_pulse_gen.sv
// eqser_pulse_gen: folds the line position into a pulse phase (single or
// double rate) and reports equalization/serration activity and band hit.
// Assumes h_pos < h_total; every mode other than 11 counts as double rate.
module eqser_pulse_gen #(
    parameter int W = 12
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] h_pos,
    input  logic [W-1:0] h_total,
    input  logic [W-1:0] v_line,
    input  logic [W-1:0] eq_end,
    input  logic [W-1:0] serr_end,
    input  logic [W-1:0] win_first,
    input  logic [W-1:0] win_last,
    output logic         eq_act,
    output logic         serr_act,
    output logic         in_band
);
    import sync_mix_pkg::*;

    logic         dbl_rate;
    logic [W-1:0] half_line;
    logic [W-1:0] phase;

    // Pick the rate and fold the position at the half line in double rate.
    always_comb begin
        dbl_rate  = (mode != MODE_PROG_SGL);
        half_line = h_total >> 1;
        if (dbl_rate && (h_pos >= half_line))
            phase = h_pos - half_line;
        else
            phase = h_pos;
    end

    // Compare the phase with the pulse ends and the line with the band.
    always_comb begin
        eq_act   = (phase < eq_end);
        serr_act = (phase < serr_end);
        in_band  = (v_line >= win_first) && (v_line <= win_last);
    end

    // Folded phase never exceeds the raw position.
    always_comb begin
        AST_PHASE_BOUND: assert (phase <= h_pos); // R8
    end
endmodule

// File: rtl/comp_mixer.sv
// comp_mixer: forms composite blank and composite sync, substituting the
// inserted pulses inside the enabled band. Inputs are active high.
module comp_mixer (
    input  sync_mix_pkg::tsrc_t src,
    input  logic                pulse_off,
    input  logic                in_band,
    input  logic                eq_act,
    input  logic                serr_act,
    output logic                csync,
    output logic                cblank
);
    logic plain_sync;

    // Merge blanking and choose between plain sync and inserted pulses.
    always_comb begin
        cblank     = src.hblank | src.vblank;
        plain_sync = src.hsync | src.vsync;
        if (!pulse_off && in_band)
            csync = src.vsync ? serr_act : eq_act;
        else
            csync = plain_sync;
    end
endmodule

// File: rtl/pin_router.sv
// pin_router: selects each pin's function from the select field, applies
// per-pin polarity and registers the result. Sync reset drives pins to 0.
module pin_router #(
    parameter int NPIN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  sync_mix_pkg::tsrc_t src,
    input  logic                csync,
    input  logic                cblank,
    input  logic [2:0]          sel,
    input  logic [NPIN-1:0]     pol,
    output logic [NPIN-1:0]     pin
);
    logic [NPIN-1:0] func;
    logic [NPIN-1:0] pin_d;
    logic            primed;

    // Table lookup of the four pin functions.
    always_comb begin
        func[0] = sel[0] ? src.vblank : cblank;
        func[1] = sel[1] ? src.vsync  : csync;
        func[2] = sel[0] ? src.hblank : (sel[2] ? src.cursor : src.hgate);
        func[3] = sel[1] ? src.hsync  : (sel[2] ? src.vint   : src.vgate);
    end

    // Per-pin polarity: a clear bit inverts to active low.
    for (genvar g = 0; g < NPIN; g++) begin : g_pol
        assign pin_d[g] = pol[g] ? func[g] : ~func[g];
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= '0;
        else        pin <= pin_d;
    end

    // Marks that one active cycle has loaded the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    AST_VSYNC_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(sel[1])) |-> (pin[1] == ($past(src.vsync) ~^ $past(pol[1])))); // R10
    AST_HSYNC_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(sel[1])) |-> (pin[3] == ($past(src.hsync) ~^ $past(pol[3])))); // R2
    AST_HBLANK_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(sel[0])) |-> (pin[2] == ($past(src.hblank) ~^ $past(pol[2])))); // R2
    AST_CBLANK_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(sel[0])) |->
        (pin[0] == (($past(src.hblank) | $past(src.vblank)) ~^ $past(pol[0])))); // R4
endmodule

// File: rtl/sync_mix_router.sv
// sync_mix_router: top level. Builds composite sync/blank with optional
// equalization/serration insertion and routes four polarity-set pins.
// Assumes timing inputs are active high and synchronous to clk.
module sync_mix_router #(
    parameter int W    = sync_mix_pkg::CW,
    parameter int NPIN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     status,
    input  logic [W-1:0]    h_pos,
    input  logic [W-1:0]    h_total,
    input  logic [W-1:0]    v_line,
    input  logic [W-1:0]    eq_end,
    input  logic [W-1:0]    serr_end,
    input  logic [W-1:0]    win_first,
    input  logic [W-1:0]    win_last,
    input  logic            hsync_i,
    input  logic            hblank_i,
    input  logic            vsync_i,
    input  logic            vblank_i,
    input  logic            hgate_i,
    input  logic            vgate_i,
    input  logic            cursor_i,
    input  logic            vint_i,
    output logic [NPIN-1:0] vid_pin
);
    import sync_mix_pkg::*;

    tsrc_t src;
    logic  eq_act, serr_act, in_band;
    logic  csync, cblank;
    logic  primed;

    // Bundle the timing inputs.
    assign src = '{hsync: hsync_i, hblank: hblank_i, vsync: vsync_i,
                   vblank: vblank_i, hgate: hgate_i, vgate: vgate_i,
                   cursor: cursor_i, vint: vint_i};

    eqser_pulse_gen #(.W(W)) i_pulse (
        .mode(status[4:3]), .h_pos(h_pos), .h_total(h_total), .v_line(v_line),
        .eq_end(eq_end), .serr_end(serr_end), .win_first(win_first),
        .win_last(win_last), .eq_act(eq_act), .serr_act(serr_act),
        .in_band(in_band));

    comp_mixer i_mix (
        .src(src), .pulse_off(status[9]), .in_band(in_band), .eq_act(eq_act),
        .serr_act(serr_act), .csync(csync), .cblank(cblank));

    pin_router #(.NPIN(NPIN)) i_route (
        .clk(clk), .rst_n(rst_n), .src(src), .csync(csync), .cblank(cblank),
        .sel(status[2:0]), .pol(status[8:5]), .pin(vid_pin));

    // Marks the first loaded output cycle for top-level checks.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    AST_PULSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(status[9]) && ($past(status[1]) == 1'b0)) |->
        (vid_pin[1] == (($past(hsync_i) | $past(vsync_i)) ~^ $past(status[6])))); // R5
    AST_SERR_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(status[9]) && $past(in_band) && $past(vsync_i)
         && ($past(status[1]) == 1'b0)) |->
        (vid_pin[1] == ($past(serr_act) ~^ $past(status[6])))); // R6
endmodule

// File: tb/test_sync_mix_router.sv
module test_sync_mix_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] status = '0;
    logic [11:0] h_pos = '0, h_total = 12'd100, v_line = '0;
    logic [11:0] eq_end = '0, serr_end = '0, win_first = '0, win_last = '0;
    logic        hs = 0, hb = 0, vs = 0, vb = 0, hg = 0, vg = 0, cu = 0, vi = 0;
    logic [3:0]  vid_pin;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    sync_mix_router i_sync_mix_router (
        .clk(clk), .rst_n(rst_n), .status(status), .h_pos(h_pos),
        .h_total(h_total), .v_line(v_line), .eq_end(eq_end),
        .serr_end(serr_end), .win_first(win_first), .win_last(win_last),
        .hsync_i(hs), .hblank_i(hb), .vsync_i(vs), .vblank_i(vb),
        .hgate_i(hg), .vgate_i(vg), .cursor_i(cu), .vint_i(vi),
        .vid_pin(vid_pin));

    // Expected pin vector from the requirements.
    function automatic logic [3:0] model();
        logic [11:0] ph, hf;
        logic cs, cb, dbl;
        logic [3:0] f, p;
        hf  = h_total / 2;
        dbl = (status[4:3] != 2'b11);
        ph  = (dbl && h_pos >= hf) ? h_pos - hf : h_pos;
        cb  = hb | vb;
        if (!status[9] && v_line >= win_first && v_line <= win_last)
            cs = vs ? (ph < serr_end) : (ph < eq_end);
        else
            cs = hs | vs;
        f[0] = status[0] ? vb : cb;
        f[1] = status[1] ? vs : cs;
        f[2] = status[0] ? hb : (status[2] ? cu : hg);
        f[3] = status[1] ? hs : (status[2] ? vi : vg);
        for (int i = 0; i < 4; i++) p[i] = status[5+i] ? f[i] : ~f[i];
        return p;
    endfunction

    task automatic check(input logic [3:0] exp, input string tag);
        n_chk++;
        if (vid_pin !== exp) begin
            n_fail++;
            $display("FAIL %s: vid_pin=%b expected=%b", tag, vid_pin, exp);
        end
    endtask

    // Inputs are set at a falling edge; the result is checked one cycle on.
    task automatic step(input string tag);
        logic [3:0] e;
        e = model();
        @(posedge clk);
        @(negedge clk);
        check(e, tag);
    endtask

    task automatic rand_srcs();
        {hs, hb, vs, vb, hg, vg, cu, vi} = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'd715));
        repeat (3) @(negedge clk);
        check(4'b0000, "R1 reset");
        rst_n = 1'b1;
        // R2/R3: every select with random polarities and sources
        for (int s = 0; s < 8; s++) begin
            status = {3'b010, 4'($urandom), 2'b11, 3'(s)};
            rand_srcs();
            step("R2 select");
        end
        for (int p = 0; p < 16; p++) begin
            status = {3'b010, 4'(p), 2'b11, 3'b000};
            rand_srcs();
            step("R3 polarity");
        end
        // R4: composite blank from each blank alone
        status = 12'b010_1111_11_000;
        {hs, hb, vs, vb, hg, vg, cu, vi} = 8'b0100_0000; step("R4 hblank only");
        {hs, hb, vs, vb, hg, vg, cu, vi} = 8'b0001_0000; step("R4 vblank only");
        // Band setup for directed pulse cases
        h_total = 12'd200; eq_end = 12'd10; serr_end = 12'd80;
        win_first = 12'd5; win_last = 12'd9;
        {hs, hb, vs, vb, hg, vg, cu, vi} = 8'b0000_0000;
        status = 12'b000_1111_01_000;
        // R6: band edges, equalization with h_pos=0
        v_line = 12'd4; hs = 1; step("R6 before band");
        v_line = 12'd5; hs = 0; h_pos = 0; step("R6 first line");
        v_line = 12'd9; step("R6 last line");
        v_line = 12'd10; hs = 0; step("R6 after band");
        // R7: eq end boundary
        v_line = 12'd6; h_pos = 12'd9;  step("R7 eq end-1");
        h_pos = 12'd10; step("R7 eq end");
        vs = 1; h_pos = 12'd79; step("R7 serr end-1");
        h_pos = 12'd80; step("R7 serr end");
        // R8: fold point in double rate, none in single rate
        vs = 0; h_pos = 12'd99;  step("R8 half-1");
        h_pos = 12'd100; step("R8 half");
        status[4:3] = 2'b11; step("R8 single at half");
        status[4:3] = 2'b00; step("R8 interlaced at half");
        // R9: illegal mode folds like progressive double
        status[4:3] = 2'b10; h_pos = 12'd104; step("R9 illegal mode");
        // R5: disable bit
        status[9] = 1; hs = 1; step("R5 pulses off");
        // R10: vsync on pin 1 and other pins unaffected in band
        status = 12'b000_1111_01_010; vs = 1; h_pos = 12'd150; step("R10 vsync pin");
        status = 12'b000_1111_01_111; step("R10 separate pins");
        // Random mix of all functions
        for (int k = 0; k < 3000; k++) begin
            status  = {2'b01, 10'($urandom)};
            h_total = 12'd20 + 12'($urandom_range(0, 300));
            h_pos   = 12'($urandom_range(0, int'(h_total) - 1));
            v_line  = 12'($urandom_range(0, 40));
            eq_end  = 12'($urandom_range(0, 60));
            serr_end = 12'($urandom_range(0, 200));
            win_first = 12'($urandom_range(0, 20));
            win_last  = win_first + 12'($urandom_range(0, 15));
            rand_srcs();
            step("R6 R7 R8 random");
        end
        // R1 again: reset mid-run clears pins
        rst_n = 1'b0; status = 12'h1E0; rand_srcs();
        @(posedge clk); @(negedge clk);
        check(4'b0000, "R1 reset mid-run");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule